// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor. Each cycle it takes the distributor's per-interrupt pending, enable, group, trigger-type and priority vectors for 64 interrupt IDs. It picks the most urgent interrupt that this processor may take and raises either the normal interrupt line or the fast interrupt line. Software talks to it through a small register port. Through that port it enables the two groups, sets a priority mask and a binary point, acknowledges and completes interrupts, and reads the running and highest-pending priorities.

The interface keeps its own set of active interrupts. Acknowledging an interrupt marks it active and sends a one-cycle strobe back to the distributor. The strobe tells the distributor which ID was taken and whether its pending bit should be dropped, which is the case for edge-triggered sources. Completing an interrupt clears its active bit and sends a matching strobe. The running priority follows the most urgent active interrupt, and a new interrupt must beat it in group priority to preempt. The register port is a valid/ready request channel paired with a valid/ready response channel.

Top module: `irqcpu_iface`

## Requirements
- R1: After reset the control register is 0, the priority mask is 0, the binary point is 2, the running priority reads 0xFF, and both interrupt lines are low.
- R2: A request is taken on a cycle where `req_valid_i` and `req_ready_o` are both high, and `req_ready_o` = !`resp_valid_o` || `resp_ready_i`. Each taken request yields exactly one response on the next cycle. The response stays valid with stable data until `resp_ready_i` is high. The register offsets are: control 0x00, priority mask 0x04, binary point 0x08, acknowledge 0x0C, completion 0x10, running priority 0x14, highest pending 0x18. Other offsets read 0 and ignore writes, and a write's response data is 0.
- R3: The control register keeps bit 0 (group-0 enable), bit 1 (group-1 enable) and bit 3 (fast-line select for group 0). All other bits read 0.
- R4: The binary point keeps 3 bits, and a written value below 2 is stored as 2.
- R5: An ID is a candidate when it is pending, enabled, not active, and its group is enabled (group bit 0 uses control bit 0, group bit 1 uses control bit 1). The winner is the candidate with the numerically lowest priority, and a tie goes to the lower ID. The highest-pending register returns the winner ID, or 1023 if there is no candidate, regardless of mask and preemption.
- R6: The winner is signalled only when three conditions hold: its priority is below the priority mask; either no ID is active or (priority & G) < (running priority & G), where G clears bits [binary point:0]; and at least one group is enabled.
- R7: A signalled group-0 winner drives `fiq_o` when control bit 3 is set. Every other signalled winner drives `irq_o`. The two lines are never high together.
- R8: Reading acknowledge while a winner is signalled returns its ID in bits [9:0] and 0 above. It also marks the ID active and pulses `ack_stb_o` for one cycle, with `ack_id_o` and with `ack_clr_pend_o` equal to that ID's edge-trigger bit. Otherwise the read returns 1023 and has no side effect.
- R9: The running priority is the lowest priority value among active IDs, or 0xFF when none is active. Writes to it are ignored.
- R10: Writing the completion register with an ID below 64 clears that ID's active bit and pulses `eoi_stb_o` with `eoi_id_o` for one cycle. An ID of 64 or more is ignored and produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pend_i | input | 64 | Pending bit per ID |
| enab_i | input | 64 | Enable bit per ID |
| grp1_i | input | 64 | Group bit per ID (1 = group 1) |
| edge_i | input | 64 | Edge-trigger bit per ID |
| prio_i | input | 512 | 8-bit priority per ID, ID n at bits [8n+7:8n] |
| req_valid_i | input | 1 | Register request valid |
| req_ready_o | output | 1 | Register request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 8 | Register byte offset |
| req_wdata_i | input | 32 | Write data |
| resp_valid_o | output | 1 | Response valid |
| resp_ready_i | input | 1 | Response ready |
| resp_rdata_o | output | 32 | Read data |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| ack_stb_o | output | 1 | Acknowledge strobe to distributor |
| ack_id_o | output | 6 | Acknowledged ID |
| ack_clr_pend_o | output | 1 | Distributor should drop the pending bit |
| eoi_stb_o | output | 1 | Completion strobe to distributor |
| eoi_id_o | output | 6 | Completed ID |

## Verification
Directed cases put two equal-priority pending IDs in front of the block. Because the tie goes to the lower ID first, and the second ID is then blocked by preemption while the highest-pending register still names it, these cases separate winner selection from the signalling gate. Random rounds draw priorities from a small set, so ties and near-ties in group priority are common. They also vary the group mix, the control bits, the mask and the binary point, which separates fast-line from normal-line routing and exercises masking against running-priority preemption. A stalled response channel shows whether the response is held and further requests are refused, and out-of-range completion IDs show whether they are ignored.

// File: rtl/irqcpu_pkg.sv
package irqcpu_pkg;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 32;
  localparam logic [ADDR_W-1:0] OFS_CTL  = 8'h00;
  localparam logic [ADDR_W-1:0] OFS_PMR  = 8'h04;
  localparam logic [ADDR_W-1:0] OFS_BPR  = 8'h08;
  localparam logic [ADDR_W-1:0] OFS_ACK  = 8'h0C;
  localparam logic [ADDR_W-1:0] OFS_EOI  = 8'h10;
  localparam logic [ADDR_W-1:0] OFS_RPR  = 8'h14;
  localparam logic [ADDR_W-1:0] OFS_HPPI = 8'h18;
  localparam logic [9:0]        SPURIOUS_ID = 10'd1023;
  localparam logic [2:0]        BPR_FLOOR   = 3'd2;
endpackage

// File: rtl/irqcpu_pick.sv
module irqcpu_pick #(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic            found,
  output logic [IDW-1:0]  win_id,
  output logic [PW-1:0]   win_prio
);
  // Scan downward with <= so that the lowest ID wins a tie.
  always_comb begin
    found    = 1'b0;
    win_id   = '0;
    win_prio = '1;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i] && prio[i*PW +: PW] <= win_prio) begin
        win_prio = prio[i*PW +: PW];
        win_id   = IDW'(i);
      end
      found = found | req[i];
    end
  end
endmodule

// File: rtl/irqcpu_active.sv
module irqcpu_active #(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            set_en,
  input  logic [IDW-1:0]  set_id,
  input  logic            clr_en,
  input  logic [IDW-1:0]  clr_id,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    active_q,
  output logic [PW-1:0]   run_prio
);
  logic          any_act;
  logic [IDW-1:0] unused_id;

  always_ff @(posedge clk) begin
    if (!rst_n) active_q <= '0;
    else begin
      if (set_en) active_q[set_id] <= 1'b1;
      if (clr_en) active_q[clr_id] <= 1'b0;
    end
  end

  irqcpu_pick #(.N(N), .PW(PW), .IDW(IDW)) u_run (
    .req(active_q), .prio(prio), .found(any_act),
    .win_id(unused_id), .win_prio(run_prio)
  );

  // R9
  rpr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q == '0) |-> (run_prio == '1));
  // R10
  clr_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> !active_q[$past(clr_id)]);
endmodule

// File: rtl/irqcpu_iface.sv
module irqcpu_iface
  import irqcpu_pkg::*;
#(
  parameter int N   = 64,
  parameter int PW  = 8,
  parameter int IDW = $clog2(N)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N-1:0]      pend_i,
  input  logic [N-1:0]      enab_i,
  input  logic [N-1:0]      grp1_i,
  input  logic [N-1:0]      edge_i,
  input  logic [N*PW-1:0]   prio_i,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              resp_valid_o,
  input  logic              resp_ready_i,
  output logic [DATA_W-1:0] resp_rdata_o,
  output logic              irq_o,
  output logic              fiq_o,
  output logic              ack_stb_o,
  output logic [IDW-1:0]    ack_id_o,
  output logic              ack_clr_pend_o,
  output logic              eoi_stb_o,
  output logic [IDW-1:0]    eoi_id_o
);
  logic [3:0]    ctl_q;
  logic [PW-1:0] pmr_q;
  logic [2:0]    bpr_q;
  logic [N-1:0]  act_q, cand;
  logic [PW-1:0] rpr, w_prio, gmask;
  logic [IDW-1:0] w_id;
  logic          w_found, preempt_ok, sig, accept, do_ack, do_eoi;
  logic [DATA_W-1:0] rdata;

  assign req_ready_o = !resp_valid_o || resp_ready_i;
  assign accept      = req_valid_i && req_ready_o;

  // Candidate vector and winner.
  always_comb begin
    for (int i = 0; i < N; i++)
      cand[i] = pend_i[i] && enab_i[i] && !act_q[i] &&
                (grp1_i[i] ? ctl_q[1] : ctl_q[0]);
  end

  irqcpu_pick #(.N(N), .PW(PW), .IDW(IDW)) u_win (
    .req(cand), .prio(prio_i), .found(w_found),
    .win_id(w_id), .win_prio(w_prio)
  );

  // Group-priority mask: clear bits [bpr:0].
  assign gmask      = PW'({PW{1'b1}} << ({1'b0, bpr_q} + 4'd1));
  assign preempt_ok = (act_q == '0) || ((w_prio & gmask) < (rpr & gmask));
  assign sig        = w_found && (w_prio < pmr_q) && preempt_ok;
  assign fiq_o      = sig && !grp1_i[w_id] && ctl_q[3];
  assign irq_o      = sig && !fiq_o;

  assign do_ack = accept && !req_write_i && (req_addr_i == OFS_ACK) && sig;
  assign do_eoi = accept && req_write_i && (req_addr_i == OFS_EOI) &&
                  (req_wdata_i[9:0] < 10'(N));

  irqcpu_active #(.N(N), .PW(PW), .IDW(IDW)) u_act (
    .clk(clk), .rst_n(rst_n),
    .set_en(do_ack), .set_id(w_id),
    .clr_en(do_eoi), .clr_id(req_wdata_i[IDW-1:0]),
    .prio(prio_i), .active_q(act_q), .run_prio(rpr)
  );

  always_comb begin
    rdata = '0;
    if (!req_write_i) begin
      case (req_addr_i)
        OFS_CTL:  rdata = DATA_W'(ctl_q & 4'b1011);
        OFS_PMR:  rdata = DATA_W'(pmr_q);
        OFS_BPR:  rdata = DATA_W'(bpr_q);
        OFS_ACK:  rdata = sig ? DATA_W'(w_id) : DATA_W'(SPURIOUS_ID);
        OFS_RPR:  rdata = DATA_W'(rpr);
        OFS_HPPI: rdata = w_found ? DATA_W'(w_id) : DATA_W'(SPURIOUS_ID);
        default:  rdata = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctl_q <= '0; pmr_q <= '0; bpr_q <= BPR_FLOOR;
      resp_valid_o <= 1'b0; resp_rdata_o <= '0;
      ack_stb_o <= 1'b0; ack_id_o <= '0; ack_clr_pend_o <= 1'b0;
      eoi_stb_o <= 1'b0; eoi_id_o <= '0;
    end else begin
      if (accept && req_write_i) begin
        case (req_addr_i)
          OFS_CTL: ctl_q <= {req_wdata_i[3], 1'b0, req_wdata_i[1:0]};
          OFS_PMR: pmr_q <= req_wdata_i[PW-1:0];
          OFS_BPR: bpr_q <= (req_wdata_i[2:0] < BPR_FLOOR) ? BPR_FLOOR : req_wdata_i[2:0];
          default: ;
        endcase
      end
      if (accept) begin
        resp_valid_o <= 1'b1;
        resp_rdata_o <= rdata;
      end else if (resp_ready_i) resp_valid_o <= 1'b0;
      ack_stb_o      <= do_ack;
      ack_id_o       <= w_id;
      ack_clr_pend_o <= do_ack && edge_i[w_id];
      eoi_stb_o      <= do_eoi;
      eoi_id_o       <= req_wdata_i[IDW-1:0];
    end
  end

  // R4
  bpr_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bpr_q >= BPR_FLOOR);
  // R7
  line_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(irq_o && fiq_o));
  // R6
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q[1:0] == 2'b00) |-> !(irq_o || fiq_o));
  // R2
  resp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid_o && !resp_ready_i) |=> (resp_valid_o && $stable(resp_rdata_o)));
  // R8
  ack_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_stb_o |-> act_q[ack_id_o]);
endmodule

// File: tb/tb_irqcpu_iface.sv
module tb_irqcpu_iface;
  localparam int N = 64;
  localparam int PW = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0] pend, enab, grp1, edg;
  logic [N*PW-1:0] prio;
  logic req_valid, req_ready, req_write, resp_valid, resp_ready;
  logic [7:0] req_addr;
  logic [31:0] req_wdata, resp_rdata;
  logic irq, fiq, ack_stb, ack_clr, eoi_stb;
  logic [5:0] ack_id, eoi_id;

  irqcpu_iface dut (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .grp1_i(grp1),
    .edge_i(edg), .prio_i(prio), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_write_i(req_write), .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .resp_valid_o(resp_valid), .resp_ready_i(resp_ready), .resp_rdata_o(resp_rdata),
    .irq_o(irq), .fiq_o(fiq), .ack_stb_o(ack_stb), .ack_id_o(ack_id),
    .ack_clr_pend_o(ack_clr), .eoi_stb_o(eoi_stb), .eoi_id_o(eoi_id)
  );

  int compared = 0, mismatched = 0;
  bit done = 0;
  logic [N-1:0] m_act;
  logic [3:0] m_ctl;
  logic [7:0] m_pmr;
  logic [2:0] m_bpr;
  logic [31:0] rd;
  logic s_ack, s_eoi, s_clr;
  logic [5:0] s_aid, s_eid;

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  function automatic logic [7:0] pr(input int i);
    return prio[i*PW +: PW];
  endfunction

  function automatic logic [7:0] m_rpr();
    logic [7:0] b = 8'hFF;
    for (int i = 0; i < N; i++) if (m_act[i] && pr(i) < b) b = pr(i);
    return b;
  endfunction

  // Winner per R5; returns -1 if none.
  function automatic int m_win();
    int w = -1;
    for (int i = 0; i < N; i++)
      if (pend[i] && enab[i] && !m_act[i] && (grp1[i] ? m_ctl[1] : m_ctl[0]))
        if (w < 0 || pr(i) < pr(w)) w = i;
    return w;
  endfunction

  // Signalled per R6.
  function automatic bit m_sig();
    int w = m_win();
    logic [7:0] gm = 8'hFF << (int'(m_bpr) + 1);
    if (w < 0) return 0;
    if (!(pr(w) < m_pmr)) return 0;
    if (m_act != '0 && !((pr(w) & gm) < (m_rpr() & gm))) return 0;
    return 1;
  endfunction

  task automatic acc(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d; resp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    rd = resp_rdata; s_ack = ack_stb; s_aid = ack_id; s_clr = ack_clr;
    s_eoi = eoi_stb; s_eid = eoi_id;
    chk("R2 resp_valid", {31'b0, resp_valid}, 1);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    acc(1, a, d);
    if (a == 8'h00) m_ctl = {d[3], 1'b0, d[1:0]};
    if (a == 8'h04) m_pmr = d[7:0];
    if (a == 8'h08) m_bpr = (d[2:0] < 3'd2) ? 3'd2 : d[2:0];
    if (a == 8'h10 && d[9:0] < 10'd64) m_act[d[5:0]] = 1'b0;
  endtask

  task automatic check_lines(input string tag);
    int w = m_win();
    bit s = m_sig();
    bit f = s && !grp1[w] && m_ctl[3];
    chk({tag, " R7 fiq"}, {31'b0, fiq}, {31'b0, f});
    chk({tag, " R6 irq"}, {31'b0, irq}, {31'b0, s && !f});
  endtask

  task automatic do_ack(input string tag);
    int w = m_win();
    bit s = m_sig();
    acc(0, 8'h0C, 0);
    if (s) begin
      chk({tag, " R8 ack id"}, rd, w);
      chk({tag, " R8 strobe"}, {26'b0, s_ack, s_aid}, {26'b0, 1'b1, 6'(w)});
      chk({tag, " R8 clr_pend"}, {31'b0, s_clr}, {31'b0, edg[w]});
      m_act[w] = 1'b1;
    end else begin
      chk({tag, " R8 spurious"}, rd, 1023);
      chk({tag, " R8 no strobe"}, {31'b0, s_ack}, 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED1234));
    pend = '0; enab = '0; grp1 = '0; edg = '0; prio = '1;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; resp_ready = 1;
    m_act = '0; m_ctl = 0; m_pmr = 0; m_bpr = 2;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1;

    // R1 reset state
    chk("R1 irq/fiq", {30'b0, irq, fiq}, 0);
    acc(0, 8'h00, 0); chk("R1 ctl", rd, 0);
    acc(0, 8'h04, 0); chk("R1 pmr", rd, 0);
    acc(0, 8'h08, 0); chk("R1 bpr", rd, 2);
    acc(0, 8'h14, 0); chk("R1 rpr", rd, 8'hFF);

    // R3 control bits, R4 floor, R2 unmapped
    wr(8'h00, 32'hFFFF_FFFF); acc(0, 8'h00, 0); chk("R3 ctl bits", rd, 32'hB);
    wr(8'h08, 0); acc(0, 8'h08, 0); chk("R4 bpr 0->2", rd, 2);
    wr(8'h08, 1); acc(0, 8'h08, 0); chk("R4 bpr 1->2", rd, 2);
    wr(8'h08, 5); acc(0, 8'h08, 0); chk("R4 bpr 5", rd, 5);
    wr(8'h08, 2);
    wr(8'h40, 32'h1234); chk("R2 write resp", rd, 0);
    acc(0, 8'h40, 0); chk("R2 unmapped", rd, 0);

    // Directed tie: IDs 5 and 9 at 0x40, group 0, fast line on
    wr(8'h04, 8'hFF);
    @(negedge clk);
    pend[5] = 1; pend[9] = 1; enab[5] = 1; enab[9] = 1; edg[5] = 1;
    prio[5*8 +: 8] = 8'h40; prio[9*8 +: 8] = 8'h40;
    @(negedge clk);
    acc(0, 8'h18, 0); chk("R5 hppi tie low id", rd, 5);
    chk("R7 fiq group0", {30'b0, fiq, irq}, 2'b10);
    do_ack("dir");
    acc(0, 8'h14, 0); chk("R9 rpr after ack", rd, 8'h40);
    check_lines("R6 blocked");
    chk("R6 no preempt", {30'b0, irq, fiq}, 0);
    acc(0, 8'h18, 0); chk("R5 hppi ignores preempt", rd, 9);
    do_ack("R8 blocked");
    wr(8'h14, 0); acc(0, 8'h14, 0); chk("R9 rpr read-only", rd, 8'h40);
    wr(8'h10, 32'd1023); chk("R10 out of range no strobe", {31'b0, s_eoi}, 0);
    acc(0, 8'h14, 0); chk("R10 out of range kept", rd, 8'h40);
    wr(8'h10, 5);
    chk("R10 eoi strobe", {26'b0, s_eoi, s_eid}, {26'b0, 1'b1, 6'd5});
    acc(0, 8'h14, 0); chk("R9 rpr idle", rd, 8'hFF);
    wr(8'h00, 32'h2); check_lines("R7 group0 disabled");
    wr(8'h00, 32'h1); chk("R7 irq when fiq off", {30'b0, irq, fiq}, 2'b10);

    // R2 back-pressure
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 8'h04; resp_ready = 0;
    @(posedge clk); @(negedge clk);
    req_addr = 8'h08;
    chk("R2 ready low while held", {31'b0, req_ready}, 0);
    repeat (3) @(negedge clk);
    chk("R2 held data", resp_rdata, 8'hFF);
    chk("R2 held valid", {31'b0, resp_valid}, 1);
    req_valid = 0; resp_ready = 1;
    @(negedge clk);
    chk("R2 drained", {31'b0, resp_valid}, 0);

    // Random rounds
    for (int it = 0; it < 400; it++) begin
      if (it % 8 == 0) begin
        wr(8'h00, $urandom & 32'hF);
        wr(8'h04, ($urandom % 4 == 0) ? 32'hFF : $urandom & 32'hFF);
        wr(8'h08, $urandom & 7);
      end
      @(negedge clk);
      for (int i = 0; i < N; i++) begin
        pend[i] = ($urandom % 3) == 0;
        enab[i] = ($urandom % 4) != 0;
        grp1[i] = $urandom % 2;
        edg[i]  = $urandom % 2;
        prio[i*8 +: 8] = 8'(($urandom % 6) * 8'h18 + ($urandom % 3) * 4);
      end
      @(negedge clk);
      check_lines("rnd");
      acc(0, 8'h18, 0);
      chk("R5 rnd hppi", rd, (m_win() < 0) ? 1023 : m_win());
      do_ack("rnd");
      acc(0, 8'h14, 0); chk("R9 rnd rpr", rd, m_rpr());
      if ($urandom % 2) begin
        int e = $urandom % 80;
        wr(8'h10, e);
        chk("R10 rnd eoi strobe", {31'b0, s_eoi}, {31'b0, e < 64});
      end
      if (it % 16 == 15)
        for (int i = 0; i < N; i++) if (m_act[i]) wr(8'h10, i);
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule